// File: doc/BRIEF.md
# Maskable Edge-Capture Interrupt Controller

This block gathers twelve interrupt request lines for a small 4-bit microcontroller. Four lines come from pins outside the chip and eight come from on-chip peripherals. Each line has a rising-edge capture flag, and that flag can be set only while the line's own mask bit is 1. The flags are split into three 4-bit request registers, and the mask bits are split into three matching 4-bit mask registers. Software reaches all of them over a 4-bit data bus with an address, a read strobe and a write strobe.

A read of a request register returns its pending flags and clears them in the same access. Writing a 1 to a flag bit clears that one flag. If a new edge arrives in the cycle that clears its flag, the flag stays set, so no event is lost. The CPU interrupt is the OR of all twelve flags, gated by a global enable bit. A separate serial-buffer-empty request goes straight to the CPU and ignores both the masks and the enable. The block applies no priority: software reads the registers and decides what to service first.

Top module: `irq_ctrl`

## Requirements
- R1: Address map. Addresses 0, 1 and 2 are the request registers. Addresses 3, 4 and 5 are the mask registers, which are read/write. Address 6 is the control register; its bit 0 is the global enable. Any other address reads as 0. Bit i of group g belongs to source 4*g+i. Group 0 is `ext_req[3:0]`, group 1 is `int_req[3:0]` and group 2 is `int_req[7:4]`.
- R2: A flag is set only by a rising edge on its source while its mask bit is 1. An edge that arrives while the mask bit is 0 sets nothing. A level that stays high sets nothing.
- R3: A read strobe on a request register address clears every flag in that register at the next clock edge. The read data in the cycle of the strobe shows the flags as they were before the clear.
- R4: A write to a request register clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R5: After reset, all flags, all mask bits and the global enable read as 0, and `cpu_irq` is 0.
- R6: When `sbe_req` is 0, `cpu_irq` is 1 exactly when the global enable is 1 and at least one flag is set.
- R7: When `sbe_req` is 1, `cpu_irq` is 1, whatever the masks, the flags and the global enable hold.
- R8: External inputs pass through a two-flop synchronizer before edge detection. An external pulse held for at least three clock cycles is captured.
- R9: If a source edge arrives in the same cycle as a read-clear or a write-1-clear of its flag, the flag ends up set.
- R10: Writing 0 to a mask bit does not clear a flag that is already set. It only blocks new edges.
- R11: Several flags can be pending in one register at the same time, and a single read returns all of them. The block applies no hardware priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req | input | 4 | External request lines; asynchronous to `clk` |
| int_req | input | 8 | On-chip request lines; synchronous to `clk` |
| sbe_req | input | 1 | Serial-buffer-empty request; bypasses masks and enable |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe; clears the addressed request register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for the addressed register (combinational) |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with its default parameters: four external lines, eight internal lines, a two-stage synchronizer and a 3-bit address. This exercises all three groups and both edge paths, the synchronized external path and the direct internal path. It also places the control register at the last used address, so unused-address decoding is within reach. The edge-versus-clear collisions are driven in the exact cycle of the read strobe and of the write strobe.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    // Width of each request/mask register and of the data bus
    localparam int GRP_W = 4;

    // Per-group bus command decoded from address and strobes
    typedef struct packed {
        logic req_rd;   // read of this group's request register
        logic req_wr;   // write-1-clear of this group's request register
        logic mask_wr;  // write of this group's mask register
    } grp_cmd_t;

    // Bits of a group's flags that are cleared this cycle
    function automatic logic [GRP_W-1:0] clr_bits(grp_cmd_t cmd, logic [GRP_W-1:0] wdata);
        logic [GRP_W-1:0] c;
        c = '0;
        if (cmd.req_rd)      c = '1;
        else if (cmd.req_wr) c = wdata;
        return c;
    endfunction

endpackage

// File: rtl/irq_ctrl_edge.sv
module irq_ctrl_edge #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    logic [W-1:0] cur;
    logic [W-1:0] prev;

    generate
        if (STAGES > 0) begin : g_sync
            logic [W-1:0] stg [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= din;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end
            assign cur = stg[STAGES-1];
        end else begin : g_direct
            assign cur = din;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= cur;
    end

    assign rise = cur & ~prev;
endmodule

// File: rtl/irq_ctrl_grp.sv
module irq_ctrl_grp
    import irq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [GRP_W-1:0] rise,
    input  grp_cmd_t         cmd,
    input  logic [GRP_W-1:0] wdata,
    output logic [GRP_W-1:0] flags,
    output logic [GRP_W-1:0] mask
);
    logic [GRP_W-1:0] clr;
    logic [GRP_W-1:0] set;

    assign clr = clr_bits(cmd, wdata);
    assign set = rise & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            mask  <= '0;
        end else begin
            // a new edge wins over a clear in the same cycle
            flags <= (flags & ~clr) | set;
            if (cmd.mask_wr) mask <= wdata;
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_EXT     = 4,
    parameter int NUM_INT     = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EXT-1:0] ext_req,
    input  logic [NUM_INT-1:0] int_req,
    input  logic              sbe_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [GRP_W-1:0]  bus_wdata,
    output logic [GRP_W-1:0]  bus_rdata,
    output logic              cpu_irq
);
    localparam int NUM_SRC   = NUM_EXT + NUM_INT;
    localparam int NUM_GRP   = NUM_SRC / GRP_W;
    localparam int MASK_BASE = NUM_GRP;
    localparam int CTRL_ADDR = 2 * NUM_GRP;

    logic [NUM_EXT-1:0] ext_rise;
    logic [NUM_INT-1:0] int_rise;
    logic [NUM_SRC-1:0] rise_vec;
    logic [NUM_SRC-1:0] flag_vec;
    logic [NUM_SRC-1:0] mask_vec;
    logic               gen_en;
    grp_cmd_t           cmd [NUM_GRP];

    irq_ctrl_edge #(.W(NUM_EXT), .STAGES(SYNC_STAGES)) u_ext_edge (
        .clk(clk), .rst(rst), .din(ext_req), .rise(ext_rise)
    );

    irq_ctrl_edge #(.W(NUM_INT), .STAGES(0)) u_int_edge (
        .clk(clk), .rst(rst), .din(int_req), .rise(int_rise)
    );

    assign rise_vec = {int_rise, ext_rise};

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            always_comb begin
                cmd[g].req_rd  = bus_rd && (bus_addr == ADDR_W'(g));
                cmd[g].req_wr  = bus_wr && (bus_addr == ADDR_W'(g));
                cmd[g].mask_wr = bus_wr && (bus_addr == ADDR_W'(MASK_BASE + g));
            end

            irq_ctrl_grp u_grp (
                .clk  (clk),
                .rst  (rst),
                .rise (rise_vec[g*GRP_W +: GRP_W]),
                .cmd  (cmd[g]),
                .wdata(bus_wdata),
                .flags(flag_vec[g*GRP_W +: GRP_W]),
                .mask (mask_vec[g*GRP_W +: GRP_W])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            gen_en <= 1'b0;
        else if (bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR)))
            gen_en <= bus_wdata[0];
    end

    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (bus_addr == ADDR_W'(g))
                bus_rdata = flag_vec[g*GRP_W +: GRP_W];
            if (bus_addr == ADDR_W'(MASK_BASE + g))
                bus_rdata = mask_vec[g*GRP_W +: GRP_W];
        end
        if (bus_addr == ADDR_W'(CTRL_ADDR))
            bus_rdata = {{(GRP_W-1){1'b0}}, gen_en};
    end

    assign cpu_irq = sbe_req | (gen_en & (|flag_vec));
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 12,
    parameter int ADDR_W  = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [GRP_W-1:0]   bus_wdata,
    input logic               sbe_req,
    input logic               cpu_irq,
    input logic [NUM_SRC-1:0] flag_vec,
    input logic [NUM_SRC-1:0] mask_vec,
    input logic [NUM_SRC-1:0] rise_vec,
    input logic               gen_en
);
    localparam int NUM_GRP = NUM_SRC / GRP_W;

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (flag_vec == '0 && mask_vec == '0 && !gen_en));

    // R2
    flag_set_cause_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_vec & ~$past(flag_vec) & ~$past(rise_vec & mask_vec)) == '0));

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !((bus_rd || bus_wr) && (bus_addr < ADDR_W'(NUM_GRP)))
        |=> (($past(flag_vec) & ~flag_vec) == '0));

    // R7
    sbe_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        sbe_req |-> cpu_irq);

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !sbe_req |-> (cpu_irq == (gen_en && (flag_vec != '0))));

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
            // R3
            read_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (bus_rd && bus_addr == ADDR_W'(g))
                |=> ((flag_vec[g*GRP_W +: GRP_W]
                      & ~$past(rise_vec[g*GRP_W +: GRP_W] & mask_vec[g*GRP_W +: GRP_W])) == '0));

            // R4
            write_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (bus_wr && !bus_rd && bus_addr == ADDR_W'(g))
                |=> ((flag_vec[g*GRP_W +: GRP_W]
                      & $past(bus_wdata & ~(rise_vec[g*GRP_W +: GRP_W] & mask_vec[g*GRP_W +: GRP_W]))) == '0)
                    && (($past(flag_vec[g*GRP_W +: GRP_W] & ~bus_wdata)
                         & ~flag_vec[g*GRP_W +: GRP_W]) == '0));

            // R9
            collide_keep_chk: assert property (@(posedge clk) disable iff (rst)
                ((bus_rd || bus_wr) && bus_addr == ADDR_W'(g))
                |=> (($past(rise_vec[g*GRP_W +: GRP_W] & mask_vec[g*GRP_W +: GRP_W])
                      & ~flag_vec[g*GRP_W +: GRP_W]) == '0));
        end
    endgenerate
endmodule

bind irq_ctrl irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .sbe_req  (sbe_req),
    .cpu_irq  (cpu_irq),
    .flag_vec (flag_vec),
    .mask_vec (mask_vec),
    .rise_vec (rise_vec),
    .gen_en   (gen_en)
);

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ext_req = '0;
    logic [7:0] int_req = '0;
    logic       sbe_req = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic       cpu_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        bit         is_irq;
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    irq_ctrl dut (
        .clk(clk), .rst(rst), .ext_req(ext_req), .int_req(int_req),
        .sbe_req(sbe_req), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_irq(cpu_irq)
    );

    // monitor: pops expected items and compares away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [3:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {3'b000, cpu_irq} : bus_rdata;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(bit is_irq, logic [3:0] exp, string tag);
        item_t it;
        it.is_irq = is_irq;
        it.exp    = exp;
        it.tag    = tag;
        sb_q.push_back(it);
    endtask

    task automatic do_read(logic [2:0] a, logic [3:0] exp, string tag);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        push(1'b0, exp, tag);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic do_write(logic [2:0] a, logic [3:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic check_irq(logic e, string tag);
        @(posedge clk); #1;
        push(1'b1, {3'b000, e}, tag);
    endtask

    task automatic pulse_int(int i);
        @(posedge clk); #1; int_req[i] = 1'b1;
        @(posedge clk); #1; int_req[i] = 1'b0;
    endtask

    task automatic pulse_ext(int i);
        @(posedge clk); #1; ext_req[i] = 1'b1;
        repeat (4) @(posedge clk);
        #1; ext_req[i] = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R5: reset state
        do_read(3'd3, 4'h0, "R5 mask0 after reset");
        do_read(3'd5, 4'h0, "R5 mask2 after reset");
        do_read(3'd6, 4'h0, "R5 enable after reset");
        do_read(3'd0, 4'h0, "R5 request0 after reset");
        check_irq(1'b0, "R5 cpu_irq after reset");

        // R2: edge while masked is dropped
        pulse_int(0);
        do_read(3'd1, 4'h0, "R2 masked edge ignored");

        // R2: a level already high when the mask opens sets nothing
        @(posedge clk); #1; int_req[5] = 1'b1;
        repeat (2) @(posedge clk);
        do_write(3'd3, 4'hF);
        do_write(3'd4, 4'hF);
        do_write(3'd5, 4'hF);
        do_read(3'd4, 4'hF, "R1 mask1 readback");
        do_read(3'd7, 4'h0, "R1 unused address reads zero");
        repeat (3) @(posedge clk);
        do_read(3'd2, 4'h0, "R2 held level ignored");

        // R3: read returns then clears
        pulse_int(0);
        do_read(3'd1, 4'h1, "R3 flag captured");
        do_read(3'd1, 4'h0, "R3 cleared by read");

        // R6 / R4
        pulse_int(1);
        pulse_int(2);
        check_irq(1'b0, "R6 enable off blocks irq");
        do_write(3'd6, 4'h1);
        do_read(3'd6, 4'h1, "R1 enable readback");
        check_irq(1'b1, "R6 enable on with flags");
        do_write(3'd1, 4'b0010);
        do_read(3'd1, 4'b0100, "R4 write one clears single flag");
        check_irq(1'b0, "R6 no flags no irq");

        // R11: several pending flags read together
        pulse_int(0);
        pulse_int(3);
        do_read(3'd1, 4'b1001, "R11 multiple flags visible");

        // R8: synchronized external path
        pulse_ext(3);
        do_read(3'd0, 4'b1000, "R8 external pulse captured");

        // R7: bypass with enable off
        do_write(3'd6, 4'h0);
        @(posedge clk); #1; sbe_req = 1'b1;
        check_irq(1'b1, "R7 sbe bypasses enable");
        do_write(3'd3, 4'h0);
        check_irq(1'b1, "R7 sbe bypasses masks");
        @(posedge clk); #1; sbe_req = 1'b0;
        check_irq(1'b0, "R7 sbe released");

        // R10: closing the mask keeps the pending flag
        pulse_int(6);
        do_write(3'd5, 4'h0);
        do_read(3'd2, 4'b0100, "R10 flag kept after mask cleared");
        do_write(3'd5, 4'hF);

        // R9: edge in the cycle of a read-clear
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = 3'd2; int_req[4] = 1'b1;
        push(1'b0, 4'h0, "R9 read before collision");
        @(posedge clk); #1;
        bus_rd = 1'b0;
        do_read(3'd2, 4'b0001, "R9 edge wins over read clear");

        // R9: edge in the cycle of a write-1-clear
        @(posedge clk); #1; int_req[4] = 1'b0;
        pulse_int(4);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 4'b0001; int_req[4] = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; int_req[4] = 1'b0;
        do_read(3'd2, 4'b0001, "R9 edge wins over write clear");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule